// File: doc/BRIEF.md
# Endpoint Packet-Commit FIFO Bridge

This block sits between a byte-wide CPU register port and a USB function core and buffers the data for one endpoint. Bytes go into a 64-byte FIFO. The consuming side sees them only after a commit event, so a packet is released whole and never one byte at a time. The commit event depends on the direction. When the host receives data (`dir_in` = 1), the CPU writes the bytes and then pulses `commit_en`; after that the core pops them one per request. When the host sends data (`dir_in` = 0), the core pushes the bytes and then signals `core_ack` after the last one; only then can the CPU read them. If the core signals `core_abort` instead, the bytes received since the last commit are dropped.

A second, smaller FIFO holds setup packets. The core fills it by pushing with `core_setup` set, and `core_ack` commits it. The CPU can read it only while `setup_en` is 1. Each FIFO tracks three pointers: a write head, a commit boundary and a read tail. This keeps staged bytes apart from released bytes without a second buffer. Sticky flags record a push that was dropped because the FIFO was full and a CPU read that found nothing committed. A system reset or the synchronous function reset `sw_rst` clears both data outputs to 0x00.

Top module: `ep_commit_bridge`

## Requirements
- R1: With `dir_in`=1, bytes written by the CPU (`cpu_wr` with `cpu_setup_sel`=0) are staged and not offered to the core: `pkt_avail` stays 0, and a `core_rd_req` gives `core_rvalid`=0 until `commit_en` is pulsed.
- R2: With `dir_in`=1, each `core_rd_req` pops one committed byte. `core_rdata` and `core_rvalid`=1 are registered and appear the cycle after the request. A request with nothing committed gives `core_rvalid`=0 and `core_rdata`=0x00.
- R3: With `dir_in`=0, bytes pushed by the core (`core_wr` with `core_setup`=0) cannot be read by the CPU until `core_ack` is pulsed.
- R4: CPU reads of the main FIFO (`cpu_rd`, `cpu_setup_sel`=0, `dir_in`=0) return committed bytes in push order. `cpu_rdata` takes the new byte on the clock edge that samples `cpu_rd`.
- R5: A commit releases exactly the bytes pushed since the previous commit. A byte pushed in the same cycle as the commit, or later, stays staged until the next commit.
- R6: A `core_abort` with `dir_in`=0 discards every staged byte of the main FIFO and leaves committed bytes readable. A push in the same cycle as the abort is dropped.
- R7: The core pushes setup bytes with `core_setup`=1, and `core_ack` commits them; `setup_avail` shows that at least one is committed. A CPU read with `cpu_setup_sel`=1 pops a setup byte only while `setup_en`=1. While `setup_en`=0 the read changes neither `cpu_rdata` nor the setup FIFO.
- R8: Both `rst_n`=0 and a synchronous `sw_rst`=1 clear `cpu_rdata` and `core_rdata` to 0x00, empty both FIFOs, and clear `ovf_flag`, `unf_flag` and `core_rvalid`.
- R9: The main FIFO holds 64 bytes, staged and committed together, and `fifo_full` is 1 at that count. A push into a full FIFO is dropped, the stored bytes stay intact, and the sticky `ovf_flag` is set.
- R10: A CPU read that finds no committed byte returns 0x00 on `cpu_rdata` and sets the sticky `unf_flag`.
- R11: A wrong-kind access has no effect. With `dir_in`=1, a main-FIFO `cpu_rd` leaves `cpu_rdata` and the FIFO unchanged. With `dir_in`=0, a `cpu_wr` stores nothing.
- R12: `fifo_empty` is 1 only when the main FIFO holds no byte at all, staged or committed. `pkt_avail` is 1 when at least one committed byte is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sw_rst | input | 1 | Synchronous function reset |
| dir_in | input | 1 | 1: host-input mode, 0: host-output mode |
| setup_en | input | 1 | Allows CPU access to the setup FIFO |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_setup_sel | input | 1 | CPU access targets the setup FIFO |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Registered CPU read byte |
| commit_en | input | 1 | CPU transfer-enable pulse (host-input commit) |
| core_rd_req | input | 1 | Core request for one byte |
| core_rdata | output | 8 | Registered byte sent to the core |
| core_rvalid | output | 1 | `core_rdata` holds a popped byte |
| core_wr | input | 1 | Core push strobe |
| core_setup | input | 1 | Core push goes to the setup FIFO |
| core_wdata | input | 8 | Core push byte |
| core_ack | input | 1 | Handshake ACK, commits received bytes |
| core_abort | input | 1 | NAK or error, drops staged bytes |
| fifo_empty | output | 1 | Main FIFO holds no byte |
| fifo_full | output | 1 | Main FIFO holds 64 bytes |
| pkt_avail | output | 1 | Main FIFO has committed bytes |
| setup_avail | output | 1 | Setup FIFO has committed bytes |
| ovf_flag | output | 1 | Sticky: a push was dropped while full |
| unf_flag | output | 1 | Sticky: a CPU read found nothing committed |

## Verification
Every strobe is sampled on one rising edge, and each result is due one cycle after that edge. The flags and `pkt_avail` follow the pointers, which move on that edge. `cpu_rdata`, `core_rdata` and `core_rvalid` are registered on the same edge. The bench drives each strobe for exactly one cycle, starting at a falling edge, and checks at the next falling edge. At that point the edge that sampled the strobe has passed and no later edge has. Wrong-kind and blocked accesses are checked by comparing the outputs with the values held just before the access, and then with a normal read that shows the FIFO contents are unchanged.

// File: rtl/ep_bridge_pkg.sv
package ep_bridge_pkg;

  // Occupancy between two wrap-bit pointers of ptr_bits width.
  function automatic int unsigned ring_gap(input int unsigned head,
                                           input int unsigned tail,
                                           input int unsigned ptr_bits);
    int unsigned mask;
    mask = (32'd1 << ptr_bits) - 32'd1;
    return (head - tail) & mask;
  endfunction

  // Next pointer value, wrapping within ptr_bits.
  function automatic int unsigned ring_next(input int unsigned ptr,
                                            input int unsigned ptr_bits);
    int unsigned mask;
    mask = (32'd1 << ptr_bits) - 32'd1;
    return (ptr + 32'd1) & mask;
  endfunction

endpackage

// File: rtl/ep_commit_fifo.sv
module ep_commit_fifo
  import ep_bridge_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          commit,
  input  logic          abort,
  output logic [DW-1:0] head_data,
  output logic          avail,
  output logic          empty,
  output logic          full,
  output logic          push_drop,
  output logic          pop_miss
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, cmt_ptr, rd_ptr;
  logic [PW-1:0] held_cnt, ready_cnt;
  logic          push_ok, pop_ok;

  assign held_cnt  = PW'(ring_gap(32'(wr_ptr), 32'(rd_ptr), PW));
  assign ready_cnt = PW'(ring_gap(32'(cmt_ptr), 32'(rd_ptr), PW));

  assign full  = (held_cnt == PW'(DEPTH));
  assign empty = (held_cnt == '0);
  assign avail = (ready_cnt != '0);

  assign push_ok   = push && !abort && !full;
  assign push_drop = push && !abort && full;
  assign pop_ok    = pop && avail;
  assign pop_miss  = pop && !avail;

  assign head_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      cmt_ptr <= '0;
      rd_ptr  <= '0;
    end else begin
      if (abort) begin
        wr_ptr <= cmt_ptr;
      end else begin
        if (commit)  cmt_ptr <= wr_ptr;
        if (push_ok) wr_ptr  <= PW'(ring_next(32'(wr_ptr), PW));
      end
      if (pop_ok) rd_ptr <= PW'(ring_next(32'(rd_ptr), PW));
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= push_data;
  end

endmodule

// File: rtl/ep_access_ctl.sv
module ep_access_ctl #(
  parameter int DW = 8
) (
  input  logic          dir_in,
  input  logic          setup_en,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cpu_setup_sel,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          commit_en,
  input  logic          core_rd_req,
  input  logic          core_wr,
  input  logic          core_setup,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_ack,
  input  logic          core_abort,
  output logic          main_push,
  output logic [DW-1:0] main_push_data,
  output logic          main_pop_cpu,
  output logic          main_pop_core,
  output logic          main_commit,
  output logic          main_abort,
  output logic          stp_push,
  output logic          stp_pop,
  output logic          stp_commit,
  output logic          stp_abort
);
  always_comb begin
    if (dir_in) begin
      main_push      = cpu_wr && !cpu_setup_sel;
      main_push_data = cpu_wdata;
      main_pop_cpu   = 1'b0;
      main_pop_core  = core_rd_req;
      main_commit    = commit_en;
      main_abort     = 1'b0;
    end else begin
      main_push      = core_wr && !core_setup;
      main_push_data = core_wdata;
      main_pop_cpu   = cpu_rd && !cpu_setup_sel;
      main_pop_core  = 1'b0;
      main_commit    = core_ack;
      main_abort     = core_abort;
    end
    stp_push   = core_wr && core_setup;
    stp_pop    = cpu_rd && cpu_setup_sel && setup_en;
    stp_commit = core_ack;
    stp_abort  = core_abort;
  end

endmodule

// File: rtl/ep_commit_bridge.sv
module ep_commit_bridge #(
  parameter int DEPTH       = 64,
  parameter int SETUP_DEPTH = 8,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          dir_in,
  input  logic          setup_en,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cpu_setup_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          commit_en,
  input  logic          core_rd_req,
  output logic [DW-1:0] core_rdata,
  output logic          core_rvalid,
  input  logic          core_wr,
  input  logic          core_setup,
  input  logic [DW-1:0] core_wdata,
  input  logic          core_ack,
  input  logic          core_abort,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          pkt_avail,
  output logic          setup_avail,
  output logic          ovf_flag,
  output logic          unf_flag
);
  // Named internal events
  logic          main_push, main_pop_cpu, main_pop_core, main_commit, main_abort;
  logic [DW-1:0] main_push_data;
  logic          stp_push, stp_pop, stp_commit, stp_abort;
  logic [DW-1:0] main_head, stp_head;
  logic          main_drop, main_miss, stp_drop, stp_miss;
  logic          stp_avail_w, unf_event, ovf_event;

  ep_access_ctl #(.DW(DW)) u_ctl (
    .dir_in        (dir_in),
    .setup_en      (setup_en),
    .cpu_wr        (cpu_wr),
    .cpu_rd        (cpu_rd),
    .cpu_setup_sel (cpu_setup_sel),
    .cpu_wdata     (cpu_wdata),
    .commit_en     (commit_en),
    .core_rd_req   (core_rd_req),
    .core_wr       (core_wr),
    .core_setup    (core_setup),
    .core_wdata    (core_wdata),
    .core_ack      (core_ack),
    .core_abort    (core_abort),
    .main_push     (main_push),
    .main_push_data(main_push_data),
    .main_pop_cpu  (main_pop_cpu),
    .main_pop_core (main_pop_core),
    .main_commit   (main_commit),
    .main_abort    (main_abort),
    .stp_push      (stp_push),
    .stp_pop       (stp_pop),
    .stp_commit    (stp_commit),
    .stp_abort     (stp_abort)
  );

  ep_commit_fifo #(.DEPTH(DEPTH), .DW(DW)) u_main (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sw_rst),
    .push      (main_push),
    .push_data (main_push_data),
    .pop       (main_pop_cpu || main_pop_core),
    .commit    (main_commit),
    .abort     (main_abort),
    .head_data (main_head),
    .avail     (pkt_avail),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .push_drop (main_drop),
    .pop_miss  (main_miss)
  );

  generate
    if (SETUP_DEPTH > 0) begin : g_setup
      logic stp_empty_unused, stp_full_unused;
      ep_commit_fifo #(.DEPTH(SETUP_DEPTH), .DW(DW)) u_setup (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_rst),
        .push      (stp_push),
        .push_data (core_wdata),
        .pop       (stp_pop),
        .commit    (stp_commit),
        .abort     (stp_abort),
        .head_data (stp_head),
        .avail     (stp_avail_w),
        .empty     (stp_empty_unused),
        .full      (stp_full_unused),
        .push_drop (stp_drop),
        .pop_miss  (stp_miss)
      );
    end else begin : g_no_setup
      assign stp_head    = '0;
      assign stp_avail_w = 1'b0;
      assign stp_drop    = 1'b0;
      assign stp_miss    = stp_pop;
    end
  endgenerate

  assign setup_avail = stp_avail_w;
  assign unf_event   = (main_pop_cpu && main_miss) || stp_miss;
  assign ovf_event   = main_drop || stp_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata   <= '0;
      core_rdata  <= '0;
      core_rvalid <= 1'b0;
      ovf_flag    <= 1'b0;
      unf_flag    <= 1'b0;
    end else if (sw_rst) begin
      cpu_rdata   <= '0;
      core_rdata  <= '0;
      core_rvalid <= 1'b0;
      ovf_flag    <= 1'b0;
      unf_flag    <= 1'b0;
    end else begin
      if (main_pop_cpu)      cpu_rdata <= pkt_avail ? main_head : '0;
      else if (stp_pop)      cpu_rdata <= stp_avail_w ? stp_head : '0;
      if (main_pop_core) begin
        core_rdata  <= pkt_avail ? main_head : '0;
        core_rvalid <= pkt_avail;
      end else begin
        core_rvalid <= 1'b0;
      end
      if (ovf_event) ovf_flag <= 1'b1;
      if (unf_event) unf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/ep_commit_bridge_chk.sv
module ep_commit_bridge_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst,
  input logic          dir_in,
  input logic          setup_en,
  input logic          cpu_rd,
  input logic          cpu_setup_sel,
  input logic [DW-1:0] cpu_rdata,
  input logic          core_rd_req,
  input logic [DW-1:0] core_rdata,
  input logic          core_rvalid,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic          pkt_avail,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          main_commit,
  input logic          main_abort
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cpu_rdata == '0) && (core_rdata == '0) && !ovf_flag && !unf_flag && fifo_empty); // R8

  AST_CORE_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_rvalid |-> $past(core_rd_req && dir_in)); // R2

  AST_AVAIL_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_avail) |-> $past(main_commit)); // R5

  AST_WRONG_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in && cpu_rd && !cpu_setup_sel && !sw_rst) |=> $stable(cpu_rdata)); // R11

  AST_SETUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_setup_sel && !setup_en && !sw_rst) |=> $stable(cpu_rdata)); // R7

  AST_ABORT_CLEARS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_abort && !sw_rst) |=> (fifo_empty == !pkt_avail)); // R6

  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !sw_rst) |=> ovf_flag); // R9

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !sw_rst) |=> unf_flag); // R10

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R12

endmodule

bind ep_commit_bridge ep_commit_bridge_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_rst       (sw_rst),
  .dir_in       (dir_in),
  .setup_en     (setup_en),
  .cpu_rd       (cpu_rd),
  .cpu_setup_sel(cpu_setup_sel),
  .cpu_rdata    (cpu_rdata),
  .core_rd_req  (core_rd_req),
  .core_rdata   (core_rdata),
  .core_rvalid  (core_rvalid),
  .fifo_empty   (fifo_empty),
  .fifo_full    (fifo_full),
  .pkt_avail    (pkt_avail),
  .ovf_flag     (ovf_flag),
  .unf_flag     (unf_flag),
  .main_commit  (main_commit),
  .main_abort   (main_abort)
);

// File: tb/ep_commit_bridge_tb.sv
`timescale 1ns/1ps
module ep_commit_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n, sw_rst, dir_in, setup_en;
  logic       cpu_wr, cpu_rd, cpu_setup_sel, commit_en;
  logic [7:0] cpu_wdata, cpu_rdata, core_rdata, core_wdata;
  logic       core_rd_req, core_rvalid, core_wr, core_setup, core_ack, core_abort;
  logic       fifo_empty, fifo_full, pkt_avail, setup_avail, ovf_flag, unf_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ep_commit_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .dir_in(dir_in), .setup_en(setup_en),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_setup_sel(cpu_setup_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .commit_en(commit_en),
    .core_rd_req(core_rd_req), .core_rdata(core_rdata), .core_rvalid(core_rvalid),
    .core_wr(core_wr), .core_setup(core_setup), .core_wdata(core_wdata),
    .core_ack(core_ack), .core_abort(core_abort), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .pkt_avail(pkt_avail), .setup_avail(setup_avail),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Each helper drives a one-cycle strobe from a falling edge; results are
  // visible at the next falling edge.
  task automatic cpu_write(input logic [7:0] b);
    cpu_wr = 1'b1; cpu_wdata = b; @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic cpu_read(input logic sel);
    cpu_rd = 1'b1; cpu_setup_sel = sel; @(negedge clk); cpu_rd = 1'b0; cpu_setup_sel = 1'b0;
  endtask
  task automatic core_push(input logic s, input logic [7:0] b);
    core_wr = 1'b1; core_setup = s; core_wdata = b; @(negedge clk);
    core_wr = 1'b0; core_setup = 1'b0;
  endtask
  task automatic core_read();
    core_rd_req = 1'b1; @(negedge clk); core_rd_req = 1'b0;
  endtask
  task automatic pulse_commit(); commit_en = 1'b1; @(negedge clk); commit_en = 1'b0; endtask
  task automatic pulse_ack();    core_ack = 1'b1;  @(negedge clk); core_ack = 1'b0;  endtask
  task automatic pulse_abort();  core_abort = 1'b1; @(negedge clk); core_abort = 1'b0; endtask
  task automatic pulse_swrst();  sw_rst = 1'b1;    @(negedge clk); sw_rst = 1'b0;    endtask

  task automatic t_reset();
    chk("R8 cpu_rdata", cpu_rdata, 0);
    chk("R8 core_rdata", core_rdata, 0);
    chk("R8 core_rvalid", core_rvalid, 0);
    chk("R12 empty", fifo_empty, 1);
    chk("R9 full", fifo_full, 0);
    chk("R8 flags", {ovf_flag, unf_flag}, 0);
  endtask

  task automatic t_host_in();
    dir_in = 1'b1;
    cpu_write(8'h11); cpu_write(8'h22); cpu_write(8'h33);
    chk("R1 not offered", pkt_avail, 0);
    chk("R12 staged not empty", fifo_empty, 0);
    core_read();
    chk("R1 no rvalid before commit", core_rvalid, 0);
    chk("R2 rdata zero on miss", core_rdata, 0);
    pulse_commit();
    chk("R1 offered after commit", pkt_avail, 1);
    core_read(); chk("R2 valid", core_rvalid, 1); chk("R2 byte0", core_rdata, 8'h11);
    core_read(); chk("R2 byte1", core_rdata, 8'h22);
    core_read(); chk("R2 byte2", core_rdata, 8'h33);
    chk("R12 drained", {pkt_avail, fifo_empty}, 2'b01);
    @(negedge clk);
    chk("R2 rvalid one cycle", core_rvalid, 0);
  endtask

  task automatic t_commit_boundary();
    dir_in = 1'b1;
    cpu_write(8'h41); cpu_write(8'h42);
    // commit and a new write in the same cycle
    commit_en = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h43; @(negedge clk);
    commit_en = 1'b0; cpu_wr = 1'b0;
    core_read(); chk("R5 first", core_rdata, 8'h41);
    core_read(); chk("R5 second", core_rdata, 8'h42);
    core_read(); chk("R5 same-cycle write stays staged", core_rvalid, 0);
    chk("R5 staged held", fifo_empty, 0);
    pulse_commit();
    core_read(); chk("R5 next commit", core_rdata, 8'h43);
    chk("R5 valid", core_rvalid, 1);
  endtask

  task automatic t_host_out();
    dir_in = 1'b0;
    core_push(1'b0, 8'hA0); core_push(1'b0, 8'hA1); core_push(1'b0, 8'hA2);
    chk("R3 not readable", pkt_avail, 0);
    cpu_read(1'b0);
    chk("R10 empty read zero", cpu_rdata, 0);
    chk("R10 underflow set", unf_flag, 1);
    pulse_ack();
    chk("R3 readable after ack", pkt_avail, 1);
    cpu_read(1'b0); chk("R4 order 0", cpu_rdata, 8'hA0);
    cpu_read(1'b0); chk("R4 order 1", cpu_rdata, 8'hA1);
    cpu_read(1'b0); chk("R4 order 2", cpu_rdata, 8'hA2);
    chk("R10 underflow sticky", unf_flag, 1);
  endtask

  task automatic t_abort();
    dir_in = 1'b0;
    core_push(1'b0, 8'hC0); pulse_ack();
    core_push(1'b0, 8'hD1); core_push(1'b0, 8'hD2);
    pulse_abort();
    core_push(1'b0, 8'hE1); pulse_ack();
    cpu_read(1'b0); chk("R6 committed kept", cpu_rdata, 8'hC0);
    cpu_read(1'b0); chk("R6 staged dropped", cpu_rdata, 8'hE1);
    chk("R6 nothing left", fifo_empty, 1);
  endtask

  task automatic t_wrong_kind();
    dir_in = 1'b0;
    core_push(1'b0, 8'h77); pulse_ack();
    cpu_read(1'b0); chk("R4 preload", cpu_rdata, 8'h77);
    cpu_write(8'h99);
    chk("R11 write ignored in output mode", fifo_empty, 1);
    dir_in = 1'b1;
    cpu_write(8'h5C); pulse_commit();
    cpu_read(1'b0);
    chk("R11 read ignored in input mode", cpu_rdata, 8'h77);
    chk("R11 fifo untouched", pkt_avail, 1);
    core_read(); chk("R11 byte intact", core_rdata, 8'h5C);
  endtask

  task automatic t_overflow();
    pulse_swrst();
    dir_in = 1'b1;
    for (int i = 0; i < 64; i++) cpu_write(8'(i + 1));
    chk("R9 full at 64", fifo_full, 1);
    chk("R9 no ovf yet", ovf_flag, 0);
    cpu_write(8'hEE);
    chk("R9 ovf set", ovf_flag, 1);
    pulse_commit();
    for (int i = 0; i < 64; i++) begin
      core_read();
      chk("R9 stored byte", core_rdata, i + 1);
    end
    chk("R9 drop left nothing", fifo_empty, 1);
    chk("R9 ovf sticky", ovf_flag, 1);
  endtask

  task automatic t_setup();
    pulse_swrst();
    dir_in = 1'b0; setup_en = 1'b0;
    core_push(1'b1, 8'h5A); core_push(1'b1, 8'h5B);
    chk("R7 not committed", setup_avail, 0);
    chk("R7 main untouched", fifo_empty, 1);
    pulse_ack();
    chk("R7 committed", setup_avail, 1);
    cpu_read(1'b1);
    chk("R7 blocked read", cpu_rdata, 0);
    chk("R7 blocked no underflow", unf_flag, 0);
    setup_en = 1'b1;
    cpu_read(1'b1); chk("R7 setup byte0", cpu_rdata, 8'h5A);
    cpu_read(1'b1); chk("R7 setup byte1", cpu_rdata, 8'h5B);
    chk("R7 drained", setup_avail, 0);
    setup_en = 1'b0;
  endtask

  task automatic t_sw_reset();
    dir_in = 1'b0;
    core_push(1'b0, 8'h6D); pulse_ack();
    cpu_read(1'b0); chk("R4 before reset", cpu_rdata, 8'h6D);
    cpu_read(1'b0);
    core_push(1'b0, 8'h6E); pulse_ack();
    pulse_swrst();
    chk("R8 sw reset data", cpu_rdata, 0);
    chk("R8 sw reset flags", {ovf_flag, unf_flag}, 0);
    chk("R8 sw reset empties", {fifo_empty, pkt_avail}, 2'b10);
  endtask

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; dir_in = 1'b1; setup_en = 1'b0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_setup_sel = 1'b0; cpu_wdata = '0;
    commit_en = 1'b0; core_rd_req = 1'b0; core_wr = 1'b0; core_setup = 1'b0;
    core_wdata = '0; core_ack = 1'b0; core_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_in();
    t_commit_boundary();
    t_host_out();
    t_abort();
    t_wrong_kind();
    t_overflow();
    t_setup();
    t_sw_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule